// File: doc/BRIEF.md
# Five-Stage Pipeline Stall Controller

This block is the interlock logic for an in-order, five-stage pipeline in which every stage takes one clock and one single-port memory serves both instruction fetch and data operands. The controller keeps its own record of the instruction in each of stages 2 to 5: a valid bit, two source register numbers, a destination register number, and two flags. One flag marks a memory operand read made in stage 3. The other marks a memory result write made in stage 5. Each cycle the fetch unit offers the instruction word it would read. The controller decides whether that fetch may use the port and whether decode may advance. Wherever a stage cannot be filled, it injects an empty slot.

There is no forwarding network. An instruction in decode that names a source register still owed by an older instruction is held until the register file can return the new value. Data accesses always take the port before instruction fetch. When a stage-3 read and a stage-5 write collide, the older write goes first and the front of the pipeline waits one cycle. Write-after-read and write-after-write orderings never stall, because issue and write-back are both in program order.

Top module: `pstall_ctrl`

## Requirements
- R1: A synchronous active-high reset empties every tracked stage: `stage_vld_o` reads 0 and `fetch_stall_o`, `decode_stall_o` and `exec_stall_o` read 0 in the cycle after the reset edge.
- R2: With no hazards the pipeline accepts one instruction per cycle. An instruction accepted in cycle c shows on `retire_dst_o` with `stage_vld_o[3]` high in cycle c+4. No stall output is raised, and retirement follows program order.
- R3: `port_sel_o` encodes the memory port owner: 0 idle, 1 instruction fetch, 2 stage-3 operand read, 3 stage-5 result write. A stage-5 write beats a stage-3 read, and both beat fetch. The value 1 appears only when `fe_vld_i` is high and `fetch_stall_o` is low.
- R4: A valid stage-3 instruction with the operand-read flag stalls fetch for exactly that one cycle, which delays all later instructions by one cycle.
- R5: A valid stage-5 instruction with the result-write flag stalls fetch for exactly that one cycle.
- R6: A decode-stage instruction whose source A or source B equals the nonzero destination of a valid instruction in stage 3 or 4 is held in decode. The number of stall cycles is 2 when the producer is the immediately preceding instruction, 1 when it is two instructions earlier, and 0 when it is three or more earlier.
- R7: A destination of register 0 never creates a dependency, and empty slots never match.
- R8: Whenever `decode_stall_o` is high, `fetch_stall_o` is also high and the offered instruction is not taken. Every instruction retires exactly once, in program order.
- R9: Every stall inserts an empty slot. After a decode-only stall, stage 3 (`stage_vld_o[1]`) is empty in the next cycle. After an execute hold, stage 4 (`stage_vld_o[2]`) is empty in the next cycle.
- R10: When a stage-3 read and a stage-5 write fall in the same cycle, the write takes the port. `exec_stall_o` and `decode_stall_o` rise for that cycle and hold stages 2 and 3. The read goes out in the next cycle, and fetch stalls for two cycles in total.
- R11: An instruction whose destination equals an earlier instruction's source (WAR) or destination (WAW) causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fe_vld_i | input | 1 | Fetch unit offers an instruction this cycle |
| fe_src_a_i | input | REG_AW | First source register of offered instruction |
| fe_src_b_i | input | REG_AW | Second source register of offered instruction |
| fe_dst_i | input | REG_AW | Destination register (0 = none) |
| fe_mrd_i | input | 1 | Instruction reads a memory operand in stage 3 |
| fe_mwr_i | input | 1 | Instruction writes its result to memory in stage 5 |
| fetch_stall_o | output | 1 | Offered instruction is not taken this cycle |
| decode_stall_o | output | 1 | Decode stage holds its instruction |
| exec_stall_o | output | 1 | Stages 2 and 3 hold due to a port collision |
| port_sel_o | output | 2 | Memory port owner this cycle (R3 encoding) |
| stage_vld_o | output | 4 | Occupancy of stages 2..5, bit 0 = stage 2 |
| retire_dst_o | output | REG_AW | Destination register of the stage-5 instruction |

## Verification
The assertions assume that the fetch unit keeps offering the same instruction until it is taken, and that `fe_vld_i` stays low during reset. The bench model advances its program counter only on a cycle with `fe_vld_i` high and `fetch_stall_o` low, and clears its offer when the program is exhausted. Every scenario runs to full drain before the next starts, so stall counts and retirement timing belong to a single program.

// File: rtl/pstall_pkg.sv
package pstall_pkg;

    // Number of tracked stages (decode, execute, memory, write-back)
    localparam int unsigned NUM_TRK = 4;

    // Positions of the tracked stages in the state vector
    localparam int unsigned ST_DEC = 0;
    localparam int unsigned ST_EXE = 1;
    localparam int unsigned ST_MEM = 2;
    localparam int unsigned ST_WB  = 3;

    // Producer stages checked for read-after-write: execute and memory
    localparam int unsigned RAW_SPAN = ST_WB - ST_EXE;

    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_FETCH = 2'd1,
        PORT_OPRD  = 2'd2,
        PORT_RSWR  = 2'd3
    } port_sel_e;

endpackage

// File: rtl/pstall_raw_chk.sv
module pstall_raw_chk #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned NPROD  = 2
) (
    input  logic                          cons_vld_i,
    input  logic [REG_AW-1:0]             cons_src_a_i,
    input  logic [REG_AW-1:0]             cons_src_b_i,
    input  logic [NPROD-1:0]              prod_vld_i,
    input  logic [NPROD-1:0][REG_AW-1:0]  prod_dst_i,
    output logic                          hit_o
);

    logic [NPROD-1:0] match;

    generate
        for (genvar p = 0; p < NPROD; p++) begin : g_prod
            logic owes;
            // A producer only owes a value if it is real and targets a nonzero register
            assign owes     = prod_vld_i[p] && (prod_dst_i[p] != '0);
            assign match[p] = owes && ((prod_dst_i[p] == cons_src_a_i) ||
                                       (prod_dst_i[p] == cons_src_b_i));
        end
    endgenerate

    assign hit_o = cons_vld_i && (|match);

endmodule

// File: rtl/pstall_port_arb.sv
module pstall_port_arb
    import pstall_pkg::*;
(
    input  logic      opr_req_i,
    input  logic      rsw_req_i,
    input  logic      fe_vld_i,
    input  logic      front_hold_i,
    output port_sel_e sel_o,
    output logic      fetch_stall_o,
    output logic      fetch_take_o,
    output logic      collide_o
);

    logic data_busy;

    always_comb begin
        data_busy     = opr_req_i || rsw_req_i;
        collide_o     = opr_req_i && rsw_req_i;
        fetch_stall_o = data_busy || front_hold_i;
        fetch_take_o  = fe_vld_i && !fetch_stall_o;
        if (rsw_req_i) begin
            sel_o = PORT_RSWR;
        end else if (opr_req_i) begin
            sel_o = PORT_OPRD;
        end else if (fetch_take_o) begin
            sel_o = PORT_FETCH;
        end else begin
            sel_o = PORT_IDLE;
        end
    end

endmodule

// File: rtl/pstall_ctrl.sv
module pstall_ctrl
    import pstall_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               fe_vld_i,
    input  logic [REG_AW-1:0]  fe_src_a_i,
    input  logic [REG_AW-1:0]  fe_src_b_i,
    input  logic [REG_AW-1:0]  fe_dst_i,
    input  logic               fe_mrd_i,
    input  logic               fe_mwr_i,
    output logic               fetch_stall_o,
    output logic               decode_stall_o,
    output logic               exec_stall_o,
    output logic [1:0]         port_sel_o,
    output logic [NUM_TRK-1:0] stage_vld_o,
    output logic [REG_AW-1:0]  retire_dst_o
);

    typedef struct packed {
        logic              vld;
        logic [REG_AW-1:0] sa;
        logic [REG_AW-1:0] sb;
        logic [REG_AW-1:0] dst;
        logic              mrd;
        logic              mwr;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_TRK-1:0] stg;
    } state_t;

    localparam slot_t EMPTY = '0;

    state_t st_d, st_q;

    // Hazard detection signals
    logic                           raw_hit;
    logic                           collide;
    logic                           front_hold;
    logic                           fetch_take;
    logic                           fetch_stall;
    port_sel_e                      port_sel;
    logic [RAW_SPAN-1:0]            prod_vld;
    logic [RAW_SPAN-1:0][REG_AW-1:0] prod_dst;
    slot_t                          fe_slot;

    generate
        for (genvar k = 0; k < RAW_SPAN; k++) begin : g_prod_tap
            assign prod_vld[k] = st_q.stg[ST_EXE + k].vld;
            assign prod_dst[k] = st_q.stg[ST_EXE + k].dst;
        end
        for (genvar s = 0; s < NUM_TRK; s++) begin : g_vld_out
            assign stage_vld_o[s] = st_q.stg[s].vld;
        end
    endgenerate

    pstall_raw_chk #(
        .REG_AW (REG_AW),
        .NPROD  (RAW_SPAN)
    ) raw_i (
        .cons_vld_i   (st_q.stg[ST_DEC].vld),
        .cons_src_a_i (st_q.stg[ST_DEC].sa),
        .cons_src_b_i (st_q.stg[ST_DEC].sb),
        .prod_vld_i   (prod_vld),
        .prod_dst_i   (prod_dst),
        .hit_o        (raw_hit)
    );

    assign front_hold = raw_hit || collide;

    pstall_port_arb arb_i (
        .opr_req_i     (st_q.stg[ST_EXE].vld && st_q.stg[ST_EXE].mrd),
        .rsw_req_i     (st_q.stg[ST_WB].vld && st_q.stg[ST_WB].mwr),
        .fe_vld_i      (fe_vld_i),
        .front_hold_i  (front_hold),
        .sel_o         (port_sel),
        .fetch_stall_o (fetch_stall),
        .fetch_take_o  (fetch_take),
        .collide_o     (collide)
    );

    always_comb begin
        fe_slot     = EMPTY;
        fe_slot.vld = 1'b1;
        fe_slot.sa  = fe_src_a_i;
        fe_slot.sb  = fe_src_b_i;
        fe_slot.dst = fe_dst_i;
        fe_slot.mrd = fe_mrd_i;
        fe_slot.mwr = fe_mwr_i;
    end

    always_comb begin
        st_d = st_q;
        // Write-back always takes whatever the memory stage holds
        st_d.stg[ST_WB] = st_q.stg[ST_MEM];
        if (collide) begin
            // Older write owns the port: hold decode and execute, bubble into memory stage
            st_d.stg[ST_MEM] = EMPTY;
            st_d.stg[ST_EXE] = st_q.stg[ST_EXE];
            st_d.stg[ST_DEC] = st_q.stg[ST_DEC];
        end else begin
            st_d.stg[ST_MEM] = st_q.stg[ST_EXE];
            if (raw_hit) begin
                st_d.stg[ST_EXE] = EMPTY;
                st_d.stg[ST_DEC] = st_q.stg[ST_DEC];
            end else begin
                st_d.stg[ST_EXE] = st_q.stg[ST_DEC];
                st_d.stg[ST_DEC] = fetch_take ? fe_slot : EMPTY;
            end
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign fetch_stall_o  = fetch_stall;
    assign decode_stall_o = front_hold;
    assign exec_stall_o   = collide;
    assign port_sel_o     = port_sel;
    assign retire_dst_o   = st_q.stg[ST_WB].dst;

endmodule

// File: rtl/pstall_ctrl_chk.sv
module pstall_ctrl_chk
    import pstall_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               fe_vld_i,
    input logic               fetch_stall_o,
    input logic               decode_stall_o,
    input logic               exec_stall_o,
    input logic [1:0]         port_sel_o,
    input logic [NUM_TRK-1:0] stage_vld_o,
    input logic [REG_AW-1:0]  retire_dst_o
);

    AST_RESET_EMPTY: assert property (@(posedge clk_i)
        rst_i |=> (stage_vld_o == '0) && !fetch_stall_o && !exec_stall_o); // R1

    AST_FETCH_GRANT_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        (port_sel_o == PORT_FETCH) |-> (fe_vld_i && !fetch_stall_o)); // R3

    AST_DATA_BLOCKS_FETCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (port_sel_o == PORT_OPRD || port_sel_o == PORT_RSWR) |-> fetch_stall_o); // R4

    AST_DECODE_FREEZES_FETCH: assert property (@(posedge clk_i) disable iff (rst_i)
        decode_stall_o |-> fetch_stall_o); // R8

    AST_DECODE_BUBBLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (decode_stall_o && !exec_stall_o) |=> !stage_vld_o[ST_EXE]); // R9

    AST_EXEC_BUBBLE: assert property (@(posedge clk_i) disable iff (rst_i)
        exec_stall_o |=> !stage_vld_o[ST_MEM]); // R9

    AST_COLLIDE_WRITE_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
        exec_stall_o |-> (port_sel_o == PORT_RSWR) && decode_stall_o); // R10

    AST_COLLIDE_READ_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        exec_stall_o |=> (port_sel_o == PORT_OPRD)); // R10

    AST_TAIL_ADVANCES: assert property (@(posedge clk_i) disable iff (rst_i)
        stage_vld_o[ST_MEM] |=> stage_vld_o[ST_WB]); // R2

endmodule

bind pstall_ctrl pstall_ctrl_chk #(.REG_AW(REG_AW)) chk_i (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .fe_vld_i       (fe_vld_i),
    .fetch_stall_o  (fetch_stall_o),
    .decode_stall_o (decode_stall_o),
    .exec_stall_o   (exec_stall_o),
    .port_sel_o     (port_sel_o),
    .stage_vld_o    (stage_vld_o),
    .retire_dst_o   (retire_dst_o)
);

// File: tb/pstall_ctrl_tb_top.sv
module pstall_ctrl_tb_top;

    localparam int AW = 5;
    localparam int PMAX = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fe_vld = 1'b0;
    logic [AW-1:0] fe_sa = '0, fe_sb = '0, fe_dst = '0;
    logic          fe_mrd = 1'b0, fe_mwr = 1'b0;
    logic          fetch_stall, decode_stall, exec_stall;
    logic [1:0]    port_sel;
    logic [3:0]    stage_vld;
    logic [AW-1:0] retire_dst;

    int checks = 0;
    int failures = 0;

    logic [AW-1:0] p_sa [PMAX];
    logic [AW-1:0] p_sb [PMAX];
    logic [AW-1:0] p_dst[PMAX];
    logic          p_mrd[PMAX];
    logic          p_mwr[PMAX];

    always #2 clk = ~clk;  // 250 MHz

    pstall_ctrl #(.REG_AW(AW)) dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .fe_vld_i       (fe_vld),
        .fe_src_a_i     (fe_sa),
        .fe_src_b_i     (fe_sb),
        .fe_dst_i       (fe_dst),
        .fe_mrd_i       (fe_mrd),
        .fe_mwr_i       (fe_mwr),
        .fetch_stall_o  (fetch_stall),
        .decode_stall_o (decode_stall),
        .exec_stall_o   (exec_stall),
        .port_sel_o     (port_sel),
        .stage_vld_o    (stage_vld),
        .retire_dst_o   (retire_dst)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PMAX; i++) begin
            p_sa[i] = '0; p_sb[i] = '0; p_dst[i] = AW'(i + 8);
            p_mrd[i] = 1'b0; p_mwr[i] = 1'b0;
        end
    endtask

    task automatic put(input int i, input int sa, input int sb, input int dst, input bit mrd, input bit mwr);
        p_sa[i] = AW'(sa); p_sb[i] = AW'(sb); p_dst[i] = AW'(dst);
        p_mrd[i] = mrd; p_mwr[i] = mwr;
    endtask

    // Runs a program to drain; expected counts come from the requirement arithmetic
    task automatic run_prog(input int n, input int e_d, input int e_f, input int e_x,
                            input int e_rd, input int e_wr, input string req);
        int pc = 0, cyc = 0, nret = 0, last = -1;
        int cd = 0, cf = 0, cx = 0, crd = 0, cwr = 0, cfe = 0, bub = 0, ord_err = 0;
        bit pend_dec = 0, pend_exe = 0;
        while (nret < n && cyc < 200) begin
            @(negedge clk);
            if (pc < n) begin
                fe_vld = 1'b1; fe_sa = p_sa[pc]; fe_sb = p_sb[pc]; fe_dst = p_dst[pc];
                fe_mrd = p_mrd[pc]; fe_mwr = p_mwr[pc];
            end else begin
                fe_vld = 1'b0;
            end
            #1;
            if (pend_dec && stage_vld[1]) bub++;
            if (pend_exe && stage_vld[2]) bub++;
            pend_dec = decode_stall && !exec_stall;
            pend_exe = exec_stall;
            if (decode_stall) cd++;
            if (exec_stall) cx++;
            if (fetch_stall && pc < n) cf++;
            if (port_sel == 2'd2) crd++;
            if (port_sel == 2'd3) cwr++;
            if (port_sel == 2'd1) cfe++;
            if (stage_vld[3]) begin
                if (nret >= n || retire_dst != p_dst[nret]) ord_err++;
                nret++;
                last = cyc;
            end
            if (fe_vld && !fetch_stall) pc++;
            cyc++;
        end
        chk(cd == e_d,  req, "decode stall cycles", cd, e_d);
        chk(cf == e_f,  req, "fetch stall cycles", cf, e_f);
        chk(cx == e_x,  req, "execute hold cycles", cx, e_x);
        chk(crd == e_rd, req, "port operand-read cycles (code 2)", crd, e_rd);
        chk(cwr == e_wr, req, "port result-write cycles (code 3)", cwr, e_wr);
        chk(cfe == n,   req, "port fetch cycles (code 1)", cfe, n);
        chk(nret == n,  req, "R8 retire count", nret, n);
        chk(ord_err == 0, req, "R8 retire order mismatches", ord_err, 0);
        chk(last == n + 3 + e_f, req, "R2 last retire cycle", last, n + 3 + e_f);
        chk(bub == 0,   req, "R9 bubble after stall", bub, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(stage_vld == 4'd0, "R1", "stage valid in reset", int'(stage_vld), 0);
        chk(!fetch_stall && !decode_stall && !exec_stall, "R1", "stalls in reset",
            int'({fetch_stall, decode_stall, exec_stall}), 0);
        chk(port_sel == 2'd0, "R1", "port idle in reset", int'(port_sel), 0);
        rst = 1'b0;

        // R2: independent stream
        clear_prog();
        run_prog(10, 0, 0, 0, 0, 0, "R2");

        // R6: RAW distance and source-slot sweep
        for (int d = 1; d <= 4; d++) begin
            for (int slot = 0; slot < 2; slot++) begin
                int stalls;
                clear_prog();
                put(0, 0, 0, 5, 0, 0);
                if (slot == 0) put(d, 5, 0, 20, 0, 0);
                else           put(d, 0, 5, 20, 0, 0);
                stalls = (d < 3) ? 3 - d : 0;
                run_prog(d + 6, stalls, stalls, 0, 0, 0, "R6");
            end
        end

        // R7: producer with register 0 as destination
        clear_prog();
        put(0, 0, 0, 0, 0, 0);
        put(1, 0, 0, 21, 0, 0);
        run_prog(7, 0, 0, 0, 0, 0, "R7");

        // R11: WAR then WAW on adjacent instructions
        clear_prog();
        put(0, 5, 6, 7, 0, 0);
        put(1, 0, 0, 5, 0, 0);
        put(2, 0, 0, 7, 0, 0);
        run_prog(7, 0, 0, 0, 0, 0, "R11");

        // R4: operand read in stage 3 swept over position
        for (int k = 0; k < 3; k++) begin
            clear_prog();
            put(k, 0, 0, 9 + k, 1, 0);
            run_prog(7, 0, 1, 0, 1, 0, "R4");
        end

        // R5: result write in stage 5
        clear_prog();
        put(0, 0, 0, 9, 0, 1);
        run_prog(7, 0, 1, 0, 0, 1, "R5");

        // R10: stage-5 write collides with stage-3 read
        clear_prog();
        put(0, 0, 0, 9, 0, 1);
        put(2, 0, 0, 11, 1, 0);
        run_prog(8, 1, 2, 1, 1, 1, "R10");

        // R3 + R6: operand read combined with dependent consumer
        clear_prog();
        put(0, 0, 0, 5, 1, 0);
        put(1, 5, 0, 22, 0, 0);
        run_prog(7, 2, 2, 0, 1, 0, "R3");

        // R1: reset in the middle of a stream
        clear_prog();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            fe_vld = 1'b1; fe_sa = '0; fe_sb = '0; fe_dst = AW'(i + 1);
            fe_mrd = 1'b0; fe_mwr = 1'b0;
        end
        @(negedge clk);
        fe_vld = 1'b0;
        rst = 1'b1;
        @(negedge clk); #1;
        chk(stage_vld == 4'd0, "R1", "stage valid after mid-run reset", int'(stage_vld), 0);
        chk(!fetch_stall && !decode_stall, "R1", "stalls after mid-run reset",
            int'({fetch_stall, decode_stall}), 0);
        rst = 1'b0;
        run_prog(6, 0, 0, 0, 0, 0, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule